// File: doc/BRIEF.md
# Operand Descriptor Stream Decoder

This block sits behind the fetch path of a processor with variable-length instructions. It takes the instruction stream one byte at a time over a valid/ready handshake. The first accepted byte is an opcode; the value 0x30 announces a second opcode byte. When the final opcode byte is accepted, an external opcode table supplies the operand count and the operand format on `op_count` and `op_kind`, and the decoder samples them on that same transfer.

Each operand normally begins with a descriptor byte. The mode in its upper nibble and the register in its lower nibble decide how many little-endian value bytes follow: none, one, two or four. A type-override prefix can come before the real descriptor. The type it sets stays in force for the rest of the instruction. For every finished operand the decoder pulses `opnd_valid` and reports the mode, the register, the override type, the assembled value and the bytes used. After the last operand it pulses `instr_done` with the total length and the opcode. A reserved encoding ends the instruction at once with an error.

Top module: `opdesc_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, `byte_ready`, `opnd_valid` and `instr_done` are low after that edge. After the first edge with `rst` low, `byte_ready` is high. The first byte accepted after reset is taken as an opcode, even if reset arrived in the middle of an instruction.
- R2: For a descriptor byte, `opnd_mode` reports bits 7:4 and `opnd_reg` reports bits 3:0.
- R3: Modes 0, 1, 2, 3 and 15 are short literals. No value bytes follow, and `opnd_value` is the descriptor byte in bits 7:0 with zeros above.
- R4: With register 15, mode 4 takes 4 value bytes, mode 5 takes 2, mode 6 takes 1, mode 7 takes 4 and mode 14 takes 4. With any other register, modes 4, 5, 6 and 7 take no value bytes and report `opnd_value` as 0.
- R5: Modes 8 and 9 take 4 value bytes, modes 10 and 11 take 2, and modes 12 and 13 take 1, whatever the register.
- R6: Value bytes fill `opnd_value` lowest byte first. Bits above the last byte received are zero.
- R7: A descriptor with mode 14 and register 0, 2, 3, 4, 6 or 7 is a prefix. It sets `opnd_etype_valid` and `opnd_etype` (the register value, in bits 2:0), and the next byte is the operand's real descriptor. The prefix counts in `opnd_len`. A second prefix inside the same operand is a reserved encoding.
- R8: An override type stays in force for all later operands of the same instruction. At the next opcode it goes back to none (`opnd_etype_valid` low).
- R9: Mode 14 with register 1, 5 or 8 to 14 is reserved. No `opnd_valid` is given for that operand. One cycle after the offending byte, `instr_done` and `instr_err` are high and `instr_len` is 0, and the next byte is taken as an opcode.
- R10: An opcode byte of 0x30 is followed by a second opcode byte, and `opcode` reports 0x30 followed by that byte. A single-byte opcode is reported with a zero upper byte. `op_count` and `op_kind` are sampled only with the final opcode byte.
- R11: `op_kind` 0 means that every operand carries a descriptor. Values 1, 2 and 3 make the first operand an implicit immediate of 1, 2 or 4 bytes that has no descriptor, reported as mode 6, 5 or 4 with register 15. Any later operands carry descriptors.
- R12: An operand is reported one cycle after its last byte is accepted. `opnd_len` counts its prefix, descriptor and value bytes. `instr_done` comes in the same cycle as the last operand, with `instr_len` equal to all bytes of the instruction, opcode included. With an `op_count` of 0, `instr_done` follows the opcode alone.
- R13: A byte is taken only when `byte_valid` and `byte_ready` are both high. A cycle with `byte_valid` low produces no output pulse and does not disturb decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_valid | input | 1 | Stream byte present |
| byte_data | input | 8 | Stream byte |
| byte_ready | output | 1 | Decoder can take a byte |
| op_count | input | CNT_W (3) | Operand count for the current opcode |
| op_kind | input | 2 | Operand format: 0 descriptor, 1/2/3 implicit byte/half/word first operand |
| opnd_valid | output | 1 | One-cycle pulse per finished operand |
| opnd_mode | output | 4 | Addressing mode |
| opnd_reg | output | 4 | Register field |
| opnd_etype_valid | output | 1 | An override type is in force |
| opnd_etype | output | 3 | Override type code |
| opnd_value | output | 32 | Literal, immediate or displacement value |
| opnd_len | output | 3 | Bytes used by this operand |
| instr_done | output | 1 | One-cycle pulse at instruction end |
| instr_err | output | 1 | Reserved encoding ended the instruction |
| instr_len | output | LEN_W (5) | Total instruction bytes, 0 on error |
| opcode | output | 16 | Opcode of the instruction |

## Verification
Two cases are the hardest to reach from the ports. The first is an override type that must carry into later operands that have no prefix of their own. The second is an error raised in the middle of an instruction that must not leak state into the next one. A random generator builds whole instructions and keeps its own record of the type in force, including prefixes placed before operands that follow an implicit immediate. It injects reserved descriptors and double prefixes at random operand positions, so the instruction after each error is checked with a cleared type. Directed sweeps cover every mode with register 15 and with an ordinary register. One reset is given halfway through a displacement.

// File: rtl/opdesc_pkg.sv
package opdesc_pkg;

    localparam int VAL_BYTES = 4;
    localparam int VAL_W     = 8 * VAL_BYTES;
    localparam int LANE_W    = $clog2(VAL_BYTES);
    localparam logic [7:0] WIDE_OPC = 8'h30;

    typedef enum logic [1:0] {
        FMT_DESC  = 2'd0,
        FMT_IMM8  = 2'd1,
        FMT_IMM16 = 2'd2,
        FMT_IMM32 = 2'd3
    } opfmt_e;

    typedef enum logic [1:0] {
        ST_OPC,
        ST_OPC2,
        ST_DESC,
        ST_EXT
    } dec_st_e;

    typedef struct packed {
        logic       prefix;
        logic       reserved;
        logic       literal;
        logic [2:0] ext;
    } dclass_t;

    // Number of value bytes that follow a descriptor of this mode/register.
    function automatic logic [2:0] ext_bytes(input logic [3:0] m, input logic [3:0] r);
        logic r15;
        r15 = (r == 4'hF);
        case (m)
            4'd4, 4'd7, 4'd14: ext_bytes = r15 ? 3'd4 : 3'd0;
            4'd5:              ext_bytes = r15 ? 3'd2 : 3'd0;
            4'd6:              ext_bytes = r15 ? 3'd1 : 3'd0;
            4'd8, 4'd9:        ext_bytes = 3'd4;
            4'd10, 4'd11:      ext_bytes = 3'd2;
            4'd12, 4'd13:      ext_bytes = 3'd1;
            default:           ext_bytes = 3'd0;
        endcase
    endfunction

    function automatic logic is_type_code(input logic [3:0] r);
        is_type_code = (r == 4'd0) || (r == 4'd2) || (r == 4'd3) ||
                       (r == 4'd4) || (r == 4'd6) || (r == 4'd7);
    endfunction

endpackage

// File: rtl/opdesc_classify.sv
module opdesc_classify
    import opdesc_pkg::*;
(
    input  logic [7:0] desc,
    output dclass_t    cls
);
    logic [3:0] mode;
    logic [3:0] rnum;

    assign mode = desc[7:4];
    assign rnum = desc[3:0];

    always_comb begin
        cls.prefix   = (mode == 4'd14) && is_type_code(rnum);
        cls.reserved = (mode == 4'd14) && !is_type_code(rnum) && (rnum != 4'hF);
        cls.literal  = (mode <= 4'd3) || (mode == 4'd15);
        cls.ext      = ext_bytes(mode, rnum);
    end
endmodule

// File: rtl/opdesc_valasm.sv
module opdesc_valasm
    import opdesc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              lit,
    input  logic              ld,
    input  logic [LANE_W-1:0] lane,
    input  logic [7:0]        din,
    output logic [VAL_W-1:0]  val_next
);
    logic [VAL_BYTES-1:0][7:0] nxt_b;
    logic [VAL_BYTES-1:0][7:0] val_q;

    for (genvar l = 0; l < VAL_BYTES; l++) begin : g_lane
        if (l == 0) begin : g_low
            assign nxt_b[l] = clr ? 8'h00 :
                              lit ? din :
                              (ld && lane == LANE_W'(l)) ? din : val_q[l];
        end else begin : g_high
            assign nxt_b[l] = (clr || lit) ? 8'h00 :
                              (ld && lane == LANE_W'(l)) ? din : val_q[l];
        end
    end

    assign val_next = nxt_b;

    always_ff @(posedge clk) begin
        if (rst) val_q <= '0;
        else     val_q <= nxt_b;
    end

    // A lane load must leave all other lanes untouched.
    a_r6_other_lanes_hold: assert property (@(posedge clk) disable iff (rst)
        (ld && !clr && !lit && lane == '0) |-> (nxt_b[VAL_BYTES-1:1] == val_q[VAL_BYTES-1:1]));
endmodule

// File: rtl/opdesc_decoder.sv
module opdesc_decoder
    import opdesc_pkg::*;
#(
    parameter  int MAX_OPS  = 4,
    localparam int CNT_W    = $clog2(MAX_OPS + 1),
    localparam int MAX_OLEN = 2 + VAL_BYTES,
    localparam int OLEN_W   = $clog2(MAX_OLEN + 1),
    localparam int LEN_W    = $clog2(2 + MAX_OPS * MAX_OLEN + 1)
)
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    output logic              byte_ready,
    input  logic [CNT_W-1:0]  op_count,
    input  logic [1:0]        op_kind,
    output logic              opnd_valid,
    output logic [3:0]        opnd_mode,
    output logic [3:0]        opnd_reg,
    output logic              opnd_etype_valid,
    output logic [2:0]        opnd_etype,
    output logic [VAL_W-1:0]  opnd_value,
    output logic [OLEN_W-1:0] opnd_len,
    output logic              instr_done,
    output logic              instr_err,
    output logic [LEN_W-1:0]  instr_len,
    output logic [15:0]       opcode
);
    dec_st_e           st_q;
    logic              ready_q;
    logic [CNT_W-1:0]  left_q;
    logic [LEN_W-1:0]  len_q;
    logic [OLEN_W-1:0] olen_q;
    logic [3:0]        mode_q, reg_q;
    logic              etv_q, pfx_q;
    logic [2:0]        et_q;
    logic [LANE_W-1:0] idx_q;
    logic [2:0]        need_q;
    logic [15:0]       opc_q;

    logic              ov_q, done_q, err_q, oetv_q;
    logic [3:0]        omode_q, oreg_q;
    logic [2:0]        oet_q;
    logic [VAL_W-1:0]  oval_q;
    logic [OLEN_W-1:0] oolen_q;
    logic [LEN_W-1:0]  ilen_q;

    dclass_t           cls;
    logic [VAL_W-1:0]  val_next;
    logic              take, desc_path, ext_path, opc_last, dbad, fin_op;
    logic              va_clr, va_lit, va_ld;
    logic [3:0]        fin_mode, fin_reg, imp_mode;
    logic [2:0]        imp_need;

    opdesc_classify u_cls (.desc(byte_data), .cls(cls));

    opdesc_valasm u_val (
        .clk(clk), .rst(rst), .clr(va_clr), .lit(va_lit), .ld(va_ld),
        .lane(idx_q), .din(byte_data), .val_next(val_next)
    );

    always_comb begin
        take      = byte_valid && ready_q;
        desc_path = take && (st_q == ST_DESC);
        ext_path  = take && (st_q == ST_EXT);
        opc_last  = take && (((st_q == ST_OPC) && (byte_data != WIDE_OPC)) || (st_q == ST_OPC2));
        dbad      = desc_path && (cls.reserved || (cls.prefix && pfx_q));
        fin_op    = (desc_path && !cls.prefix && !cls.reserved && (cls.ext == 3'd0)) ||
                    (ext_path && (({1'b0, idx_q} + 3'd1) == need_q));
        fin_mode  = (st_q == ST_DESC) ? byte_data[7:4] : mode_q;
        fin_reg   = (st_q == ST_DESC) ? byte_data[3:0] : reg_q;
        va_clr    = take && ((st_q == ST_OPC) || (st_q == ST_OPC2) ||
                             ((st_q == ST_DESC) && !cls.literal));
        va_lit    = desc_path && cls.literal;
        va_ld     = ext_path;
        case (opfmt_e'(op_kind))
            FMT_IMM8:  begin imp_need = 3'd1; imp_mode = 4'd6; end
            FMT_IMM16: begin imp_need = 3'd2; imp_mode = 4'd5; end
            default:   begin imp_need = 3'd4; imp_mode = 4'd4; end
        endcase
    end

    always_ff @(posedge clk) begin
        ov_q   <= 1'b0;
        done_q <= 1'b0;
        err_q  <= 1'b0;
        if (rst) begin
            st_q <= ST_OPC;   ready_q <= 1'b0;  left_q <= '0;  len_q <= '0;
            olen_q <= '0;     mode_q <= '0;     reg_q <= '0;   etv_q <= 1'b0;
            pfx_q <= 1'b0;    et_q <= '0;       idx_q <= '0;   need_q <= '0;
            opc_q <= '0;      oetv_q <= 1'b0;   omode_q <= '0; oreg_q <= '0;
            oet_q <= '0;      oval_q <= '0;     oolen_q <= '0; ilen_q <= '0;
        end else begin
            ready_q <= 1'b1;
            if (take) begin
                case (st_q)
                    ST_OPC: begin
                        opc_q <= {8'h00, byte_data};
                        len_q <= LEN_W'(1);
                        etv_q <= 1'b0;
                        et_q  <= '0;
                        if (byte_data == WIDE_OPC) st_q <= ST_OPC2;
                    end
                    ST_OPC2: begin
                        opc_q <= {opc_q[7:0], byte_data};
                        len_q <= LEN_W'(2);
                    end
                    ST_DESC: begin
                        len_q  <= len_q + 1'b1;
                        olen_q <= olen_q + 1'b1;
                        if (dbad) begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                            ilen_q <= '0;
                            st_q   <= ST_OPC;
                        end else if (cls.prefix) begin
                            pfx_q <= 1'b1;
                            etv_q <= 1'b1;
                            et_q  <= byte_data[2:0];
                        end else begin
                            mode_q <= byte_data[7:4];
                            reg_q  <= byte_data[3:0];
                            need_q <= cls.ext;
                            idx_q  <= '0;
                            if (cls.ext != 3'd0) st_q <= ST_EXT;
                        end
                    end
                    default: begin
                        len_q  <= len_q + 1'b1;
                        olen_q <= olen_q + 1'b1;
                        idx_q  <= idx_q + 1'b1;
                    end
                endcase
            end
            if (opc_last) begin
                left_q <= op_count;
                olen_q <= '0;
                pfx_q  <= 1'b0;
                idx_q  <= '0;
                if (op_count == '0) begin
                    done_q <= 1'b1;
                    ilen_q <= (st_q == ST_OPC) ? LEN_W'(1) : LEN_W'(2);
                    st_q   <= ST_OPC;
                end else if (opfmt_e'(op_kind) != FMT_DESC) begin
                    mode_q <= imp_mode;
                    reg_q  <= 4'hF;
                    need_q <= imp_need;
                    st_q   <= ST_EXT;
                end else begin
                    st_q <= ST_DESC;
                end
            end
            if (fin_op) begin
                ov_q    <= 1'b1;
                omode_q <= fin_mode;
                oreg_q  <= fin_reg;
                oetv_q  <= etv_q;
                oet_q   <= et_q;
                oval_q  <= val_next;
                oolen_q <= olen_q + 1'b1;
                left_q  <= left_q - 1'b1;
                olen_q  <= '0;
                pfx_q   <= 1'b0;
                if (left_q == CNT_W'(1)) begin
                    done_q <= 1'b1;
                    ilen_q <= len_q + 1'b1;
                    st_q   <= ST_OPC;
                end else begin
                    st_q <= ST_DESC;
                end
            end
        end
    end

    assign byte_ready       = ready_q;
    assign opnd_valid       = ov_q;
    assign opnd_mode        = omode_q;
    assign opnd_reg         = oreg_q;
    assign opnd_etype_valid = oetv_q;
    assign opnd_etype       = oet_q;
    assign opnd_value       = oval_q;
    assign opnd_len         = oolen_q;
    assign instr_done       = done_q;
    assign instr_err        = err_q;
    assign instr_len        = ilen_q;
    assign opcode           = opc_q;

    // R9: an aborted instruction reports length zero
    a_r9_err_zero_len: assert property (@(posedge clk) disable iff (rst)
        (instr_done && instr_err) |-> (instr_len == '0));
    // R9: a reserved mode-14 form never appears as a finished operand
    a_r9_no_reserved_out: assert property (@(posedge clk) disable iff (rst)
        opnd_valid |-> !((opnd_mode == 4'd14) && (opnd_reg != 4'hF)));
    // R3: a literal carries its own descriptor byte as value
    a_r3_literal_value: assert property (@(posedge clk) disable iff (rst)
        (opnd_valid && ((opnd_mode <= 4'd3) || (opnd_mode == 4'd15)))
        |-> (opnd_value == {{(VAL_W-8){1'b0}}, opnd_mode, opnd_reg}));
    // R12: operand length lies between its value bytes and value bytes plus descriptor and prefix
    a_r12_opnd_len_range: assert property (@(posedge clk) disable iff (rst)
        opnd_valid |-> ((4'(opnd_len) >= 4'(ext_bytes(opnd_mode, opnd_reg))) &&
                        (4'(opnd_len) <= 4'(ext_bytes(opnd_mode, opnd_reg)) + 4'd2)));
    // R6: a one-byte value leaves the upper bits zero
    a_r6_byte_zero_ext: assert property (@(posedge clk) disable iff (rst)
        (opnd_valid && (ext_bytes(opnd_mode, opnd_reg) == 3'd1)) |-> (opnd_value[VAL_W-1:8] == '0));
    // R12: a clean end always has a non-zero length
    a_r12_done_len: assert property (@(posedge clk) disable iff (rst)
        (instr_done && !instr_err) |-> (instr_len != '0));
    // R1: reset drops the handshake
    a_r1_ready_low_after_reset: assert property (@(posedge clk)
        rst |=> !byte_ready);
endmodule

// File: tb/opdesc_decoder_tb_top.sv
module opdesc_decoder_tb_top;
    localparam int CNT_W = 3;
    localparam int LEN_W = 5;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst;
    logic             byte_valid;
    logic [7:0]       byte_data;
    logic             byte_ready;
    logic [CNT_W-1:0] op_count;
    logic [1:0]       op_kind;
    logic             opnd_valid, opnd_etype_valid, instr_done, instr_err;
    logic [3:0]       opnd_mode, opnd_reg;
    logic [2:0]       opnd_etype, opnd_len;
    logic [31:0]      opnd_value;
    logic [LEN_W-1:0] instr_len;
    logic [15:0]      opcode;

    opdesc_decoder #(.MAX_OPS(4)) dut_i (
        .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_ready(byte_ready), .op_count(op_count), .op_kind(op_kind),
        .opnd_valid(opnd_valid), .opnd_mode(opnd_mode), .opnd_reg(opnd_reg),
        .opnd_etype_valid(opnd_etype_valid), .opnd_etype(opnd_etype),
        .opnd_value(opnd_value), .opnd_len(opnd_len), .instr_done(instr_done),
        .instr_err(instr_err), .instr_len(instr_len), .opcode(opcode)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // stream under construction
    logic [7:0] sb[0:63];
    int         sev[0:63];
    bit         sdone[0:63];
    int         scnt[0:63];
    int         skind[0:63];
    int         sn, opc_pos, cur_kind;
    // expected operands
    logic [3:0]  e_mode[0:7];
    logic [3:0]  e_reg[0:7];
    bit          e_etv[0:7];
    logic [2:0]  e_et[0:7];
    logic [2:0]  e_len[0:7];
    logic [31:0] e_val[0:7];
    string       e_tag[0:7];
    int          en;
    bit          cur_etv, bad;
    logic [2:0]  cur_et;
    logic [15:0] exp_opc;
    int          exp_len;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL R13 watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    function automatic int ext_of(input int m, input int r);
        case (m)
            4, 7, 14: return (r == 15) ? 4 : 0;
            5:        return (r == 15) ? 2 : 0;
            6:        return (r == 15) ? 1 : 0;
            8, 9:     return 4;
            10, 11:   return 2;
            12, 13:   return 1;
            default:  return 0;
        endcase
    endfunction

    function automatic logic [31:0] mask_val(input logic [31:0] v, input int nb);
        if (nb >= 4) return v;
        if (nb == 0) return 32'h0;
        return v & ((32'h1 << (8 * nb)) - 32'h1);
    endfunction

    function automatic int pick_type();
        case ($urandom_range(0, 5))
            0: return 0; 1: return 2; 2: return 3;
            3: return 4; 4: return 6; default: return 7;
        endcase
    endfunction

    function automatic int pick_reserved();
        case ($urandom_range(0, 8))
            0: return 1;  1: return 5;  2: return 8;  3: return 9; 4: return 10;
            5: return 11; 6: return 12; 7: return 13; default: return 14;
        endcase
    endfunction

    task automatic push(input logic [7:0] b, input int ev);
        sb[sn]    = b;
        sev[sn]   = ev;
        sdone[sn] = 1'b0;
        scnt[sn]  = $urandom_range(0, 4);
        skind[sn] = $urandom_range(0, 3);
        sn++;
    endtask

    task automatic begin_instr(input bit two, input logic [7:0] lo, input int kind);
        sn = 0; en = 0; cur_etv = 1'b0; cur_et = 3'd0; bad = 1'b0; cur_kind = kind;
        if (two) begin
            push(8'h30, -1);
            exp_opc = {8'h30, lo};
        end else begin
            exp_opc = {8'h00, lo};
        end
        push(lo, -1);
        opc_pos = sn - 1;
        skind[opc_pos] = kind;
    endtask

    task automatic add_imm(input logic [31:0] v);
        int nb;
        nb = (cur_kind == 1) ? 1 : (cur_kind == 2) ? 2 : 4;
        for (int k = 0; k < nb; k++) push(v[8*k +: 8], -1);
        sev[sn-1] = en;
        e_mode[en] = (cur_kind == 1) ? 4'd6 : (cur_kind == 2) ? 4'd5 : 4'd4;
        e_reg[en]  = 4'hF;
        e_etv[en]  = cur_etv;
        e_et[en]   = cur_et;
        e_len[en]  = 3'(nb);
        e_val[en]  = mask_val(v, nb);
        e_tag[en]  = "R11";
        en++;
    endtask

    task automatic add_desc(input int pfx, input int m, input int r, input logic [31:0] v);
        int nb, ol;
        logic [7:0] d;
        ol = 0;
        if (pfx >= 0) begin
            push({4'hE, 4'(pfx)}, -1);
            cur_etv = 1'b1;
            cur_et  = 3'(pfx);
            ol++;
        end
        d = {4'(m), 4'(r)};
        push(d, -1);
        ol++;
        nb = ext_of(m, r);
        for (int k = 0; k < nb; k++) push(v[8*k +: 8], -1);
        ol += nb;
        sev[sn-1] = en;
        e_mode[en] = 4'(m);
        e_reg[en]  = 4'(r);
        e_etv[en]  = cur_etv;
        e_et[en]   = cur_et;
        e_len[en]  = 3'(ol);
        if (m <= 3 || m == 15) e_val[en] = {24'h0, d};
        else                   e_val[en] = mask_val(v, nb);
        if (pfx >= 0)                   e_tag[en] = "R7";
        else if (cur_etv)               e_tag[en] = "R8";
        else if (m <= 3 || m == 15)     e_tag[en] = "R2 R3";
        else if (m >= 8 && m <= 13)     e_tag[en] = "R5 R6";
        else                            e_tag[en] = "R4 R6";
        en++;
    endtask

    task automatic add_bad(input int pfx, input logic [7:0] d);
        if (pfx >= 0) push({4'hE, 4'(pfx)}, -1);
        push(d, -1);
        bad = 1'b1;
    endtask

    task automatic finish_instr(input int declared);
        scnt[opc_pos] = declared;
        sdone[sn-1]   = 1'b1;
        exp_len       = bad ? 0 : sn;
    endtask

    task automatic play();
        for (int i = 0; i < sn; i++) begin
            if ($urandom_range(0, 3) == 0) begin
                byte_valid = 1'b0;
                byte_data  = 8'($urandom);
                op_count   = 3'($urandom_range(0, 4));
                op_kind    = 2'($urandom);
                @(posedge clk);
                @(negedge clk);
                chk(!opnd_valid && !instr_done, "R13 idle cycle",
                    {62'h0, opnd_valid, instr_done}, 64'h0);
            end
            byte_valid = 1'b1;
            byte_data  = sb[i];
            op_count   = 3'(scnt[i]);
            op_kind    = 2'(skind[i]);
            @(posedge clk);
            @(negedge clk);
            byte_valid = 1'b0;
            if (sev[i] >= 0) begin
                automatic int k = sev[i];
                automatic logic [63:0] act, exp;
                act = {17'h0, opnd_valid, opnd_mode, opnd_reg, opnd_etype_valid,
                       opnd_etype, opnd_len, opnd_value};
                exp = {17'h0, 1'b1, e_mode[k], e_reg[k], e_etv[k], e_et[k], e_len[k], e_val[k]};
                chk(act == exp, {e_tag[k], " R12 operand"}, act, exp);
            end else begin
                chk(!opnd_valid, "R13 no operand yet", {63'h0, opnd_valid}, 64'h0);
            end
            if (sdone[i]) begin
                automatic logic [63:0] act, exp;
                act = {40'h0, instr_done, instr_err, instr_len, opcode};
                exp = {40'h0, 1'b1, bad, 5'(exp_len), exp_opc};
                chk(act == exp, bad ? "R9 abort" : (exp_opc[15:8] == 8'h30 ? "R10 R12 done" : "R12 done"),
                    act, exp);
            end else begin
                chk(!instr_done, "R12 no early done", {63'h0, instr_done}, 64'h0);
            end
        end
    endtask

    task automatic rand_instr();
        bit two;
        logic [7:0] lo;
        int cnt, kind, errpos, start;
        two = ($urandom_range(0, 4) == 0);
        do lo = 8'($urandom); while (lo == 8'h30);
        cnt  = $urandom_range(0, 4);
        kind = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 3) : 0;
        errpos = ($urandom_range(0, 7) == 0 && cnt > 0) ? $urandom_range(0, cnt - 1) : -1;
        begin_instr(two, lo, kind);
        start = 0;
        if (cnt > 0 && kind != 0 && errpos != 0) begin
            add_imm($urandom);
            start = 1;
        end else if (cnt > 0 && kind != 0) begin
            skind[opc_pos] = 0;
            cur_kind = 0;
        end
        for (int k = start; k < cnt; k++) begin
            if (k == errpos) begin
                if ($urandom_range(0, 1) == 0) add_bad(-1, {4'hE, 4'(pick_reserved())});
                else add_bad(pick_type(), {4'hE, 4'(pick_type())});
                break;
            end else begin
                automatic int m = $urandom_range(0, 15);
                automatic int r = $urandom_range(0, 15);
                automatic int p = ($urandom_range(0, 4) == 0) ? pick_type() : -1;
                if (m >= 4 && m <= 7 && $urandom_range(0, 1) == 0) r = 15;
                if (m == 14) r = 15;
                add_desc(p, m, r, $urandom);
            end
        end
        finish_instr(cnt);
        play();
    endtask

    initial begin
        rst = 1'b1;
        byte_valid = 1'b0;
        byte_data = 8'h00;
        op_count = '0;
        op_kind = 2'd0;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!byte_ready && !opnd_valid && !instr_done, "R1 reset state",
            {61'h0, byte_ready, opnd_valid, instr_done}, 64'h0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(byte_ready, "R1 ready after reset", {63'h0, byte_ready}, 64'h1);

        // R12: zero-operand instruction
        begin_instr(0, 8'h14, 0);
        finish_instr(0);
        play();

        // R10: two-byte opcode with two literals (mode 15 and mode 0)
        begin_instr(1, 8'h1C, 0);
        add_desc(-1, 15, 15, 0);
        add_desc(-1, 0, 5, 0);
        finish_instr(2);
        play();

        // R7 and R8: prefix carried to a later operand, then cleared
        begin_instr(0, 8'h84, 0);
        add_desc(6, 4, 3, 0);
        add_desc(-1, 8, 9, 32'h1234_5678);
        add_desc(-1, 12, 1, 32'h0000_00F0);
        finish_instr(3);
        play();
        begin_instr(0, 8'h84, 0);
        add_desc(-1, 10, 2, 32'h0000_BEEF);
        finish_instr(1);
        play();

        // R9: reserved mode-14 register after one good operand
        begin_instr(0, 8'h90, 0);
        add_desc(-1, 5, 15, 32'h0000_A55A);
        add_bad(-1, 8'hE5);
        finish_instr(3);
        play();

        // R7 and R9: double prefix inside one operand
        begin_instr(0, 8'h91, 0);
        add_bad(2, 8'hE7);
        finish_instr(1);
        play();

        // R11: implicit word immediate followed by a prefixed descriptor operand
        begin_instr(0, 8'h2C, 3);
        add_imm(32'hDEAD_BEEF);
        add_desc(7, 6, 15, 32'h0000_0081);
        finish_instr(2);
        play();

        // R4 and R5: every mode with register 15 and with an ordinary register
        for (int m = 0; m < 16; m++) begin
            for (int s = 0; s < 2; s++) begin
                automatic int r = (s == 0) ? 15 : 3;
                if (m == 14 && r != 15) continue;
                begin_instr(0, 8'h40, 0);
                add_desc(-1, m, r, $urandom);
                finish_instr(1);
                play();
            end
        end

        // R1: reset halfway through a word displacement
        byte_valid = 1'b1; byte_data = 8'h11; op_count = 3'd2; op_kind = 2'd0;
        @(posedge clk); @(negedge clk);
        byte_data = 8'h8A;
        @(posedge clk); @(negedge clk);
        byte_data = 8'h77;
        @(posedge clk); @(negedge clk);
        byte_valid = 1'b0;
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(!byte_ready && !opnd_valid && !instr_done, "R1 mid-instruction reset",
            {61'h0, byte_ready, opnd_valid, instr_done}, 64'h0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        begin_instr(0, 8'h22, 0);
        add_desc(-1, 9, 4, 32'hCAFE_F00D);
        finish_instr(1);
        play();

        for (int t = 0; t < 300; t++) rand_instr();

        summary();
        $finish;
    end
endmodule